// File: doc/BRIEF.md
# Seconds Countdown Alarm with Interrupt and Wakeup

This block counts down a programmed number of seconds and flags the moment the count runs out. Software writes an interval into the load register, which immediately becomes the remaining count, and then sets the run bit. Each pulse on the one-second tick input takes one off the remaining count while running. When the count steps from one to zero, a sticky pending flag is raised and the counter parks at zero. The pending flag reaches the interrupt line only through the interrupt-enable bit, and it reaches the wakeup line only through the wakeup-enable bit. The remaining count can be read at any time.

A second pending flag records hits from an external weekly wall-clock comparator. The block holds only that source's enable, interrupt enable and write-one-to-clear status. The comparator itself is not part of this block. To reprogram the alarm, software stops the counter, clears the pending flag, writes zero to the load register, and then writes the new interval. A load of zero never raises pending, so the intermediate zero load is harmless.

The register port is a simple single-cycle write strobe with a word index. Reads are combinational from the index.

Top module: `sec_countdown_alarm`

## Requirements
- R1: After reset every register reads 0, and both irq_o and wake_o are low.
- R2: A write to index 0 (load) sets the remaining count, read at index 1, to the written value on the next cycle. Index 0 reads back the last written interval.
- R3: The remaining count drops by one on a cycle where sec_tick is high and run bit 0 at index 2 is 1. In every other cycle it is unchanged.
- R4: When the count steps from 1 to 0, pending bit 0 at index 4 is set. The count then stays at 0 under further ticks.
- R5: Loading 0, with the counter running and ticking, never sets pending.
- R6: Writing index 4 with bit 0 = 1 clears the counter pending flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R7: If the counter reaches zero in the same cycle that software clears the flag, the flag ends up set.
- R8: irq_o is high when counter pending and interrupt enable (index 3 bit 0) are both set, or when weekly pending and weekly interrupt enable (index 7 bit 0) are both set. wake_o is high only when counter pending and wake enable (index 5 bit 0) are both set.
- R9: A load write in the same cycle as a running tick takes the written value, with no decrement.
- R10: week_hit sets the weekly pending flag (index 8 bit 0) only while weekly enable (index 6 bit 0) is 1. Writing 1 to index 8 bit 0 clears that flag.
- R11: The full 32-bit range works: a load of 0xFFFFFFFF steps to 0xFFFFFFFE on one tick.
- R12: Indices 9 to 15 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse once per second |
| week_hit | input | 1 | One-cycle pulse from the weekly comparator |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word index |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| irq_o | output | 1 | Interrupt request |
| wake_o | output | 1 | Wakeup request |

## Verification
The bench targets the cycle on which the count reaches zero. If pending were set one tick early or late, or on a load of zero, the status read would be wrong. If the counter wrapped below zero, the remaining count would read 0xFFFFFFFF instead of 0. Two same-cycle collisions are forced directly: a clear against an expiry, and a load against a tick. A design with the wrong priority would lose the alarm or decrement the new interval. The separate gating of the two outputs is checked by enabling each path in turn, so that a wake line that followed the interrupt enable would show up.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int ADDR_W  = 4;
  localparam int NUM_EVT = 2;
  localparam int EVT_CNT  = 0;
  localparam int EVT_WEEK = 1;

  typedef enum logic [ADDR_W-1:0] {
    SEL_LOAD   = 4'd0,
    SEL_REMAIN = 4'd1,
    SEL_RUN    = 4'd2,
    SEL_IRQEN  = 4'd3,
    SEL_STAT   = 4'd4,
    SEL_WAKE   = 4'd5,
    SEL_WKEN   = 4'd6,
    SEL_WKIRQ  = 4'd7,
    SEL_WKSTAT = 4'd8
  } sel_e;
endpackage

// File: rtl/ca_regs.sv
module ca_regs
  import ca_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [CNT_W-1:0]     remain,
  input  logic [NUM_EVT-1:0]   pend,
  output logic [DATA_W-1:0]    rdata,
  output logic                 load_stb,
  output logic [CNT_W-1:0]     load_val,
  output logic                 run_en,
  output logic [NUM_EVT-1:0]   irq_en,
  output logic                 wake_en,
  output logic                 week_en,
  output logic [NUM_EVT-1:0]   clr
);
  logic [CNT_W-1:0] load_q, load_d;
  logic run_q, run_d, cie_q, cie_d, wake_q, wake_d;
  logic wken_q, wken_d, wkie_q, wkie_d;
  logic hit_load, hit_run, hit_ie, hit_wake, hit_wken, hit_wkie;

  always_comb begin
    hit_load = we && (addr == SEL_LOAD);
    hit_run  = we && (addr == SEL_RUN);
    hit_ie   = we && (addr == SEL_IRQEN);
    hit_wake = we && (addr == SEL_WAKE);
    hit_wken = we && (addr == SEL_WKEN);
    hit_wkie = we && (addr == SEL_WKIRQ);
    load_d = hit_load ? wdata[CNT_W-1:0] : load_q;
    run_d  = hit_run  ? wdata[0] : run_q;
    cie_d  = hit_ie   ? wdata[0] : cie_q;
    wake_d = hit_wake ? wdata[0] : wake_q;
    wken_d = hit_wken ? wdata[0] : wken_q;
    wkie_d = hit_wkie ? wdata[0] : wkie_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      run_q  <= 1'b0;
      cie_q  <= 1'b0;
      wake_q <= 1'b0;
      wken_q <= 1'b0;
      wkie_q <= 1'b0;
    end else begin
      load_q <= load_d;
      run_q  <= run_d;
      cie_q  <= cie_d;
      wake_q <= wake_d;
      wken_q <= wken_d;
      wkie_q <= wkie_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      SEL_LOAD:   rdata = DATA_W'(load_q);
      SEL_REMAIN: rdata = DATA_W'(remain);
      SEL_RUN:    rdata[0] = run_q;
      SEL_IRQEN:  rdata[0] = cie_q;
      SEL_STAT:   rdata[0] = pend[EVT_CNT];
      SEL_WAKE:   rdata[0] = wake_q;
      SEL_WKEN:   rdata[0] = wken_q;
      SEL_WKIRQ:  rdata[0] = wkie_q;
      SEL_WKSTAT: rdata[0] = pend[EVT_WEEK];
      default:    rdata = '0;
    endcase
  end

  assign load_stb         = hit_load;
  assign load_val         = wdata[CNT_W-1:0];
  assign run_en           = run_q;
  assign irq_en[EVT_CNT]  = cie_q;
  assign irq_en[EVT_WEEK] = wkie_q;
  assign wake_en          = wake_q;
  assign week_en          = wken_q;
  assign clr[EVT_CNT]     = we && (addr == SEL_STAT) && wdata[0];
  assign clr[EVT_WEEK]    = we && (addr == SEL_WKSTAT) && wdata[0];

  // R12: a write to an index outside the map leaves the run bit alone
  assert_unmapped_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr > SEL_WKSTAT) |=> $stable(run_q));
endmodule

// File: rtl/ca_counter.sv
module ca_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic             load_stb,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] remain,
  output logic             hit
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic step;

  always_comb begin
    step  = run_en && tick && (cnt_q != '0);
    cnt_d = cnt_q;
    hit   = 1'b0;
    if (load_stb) begin
      cnt_d = load_val;
    end else if (step) begin
      cnt_d = cnt_q - ONE;
      hit   = (cnt_q == ONE);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign remain = cnt_q;

  assert_load_takes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_stb |=> cnt_q == $past(load_val));
  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && !(run_en && tick)) |=> $stable(cnt_q));
  assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && run_en && tick && cnt_q != '0) |=> cnt_q == $past(cnt_q) - ONE);
  assert_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_stb && cnt_q == '0) |=> cnt_q == '0);
endmodule

// File: rtl/ca_pend.sv
module ca_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_r, q_d;

  always_comb q_d = set | (q_r & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= 1'b0;
    else        q_r <= q_d;
  end

  assign q = q_r;

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q_r);
  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q_r);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (q_r && !clr) |=> q_r);
endmodule

// File: rtl/sec_countdown_alarm.sv
module sec_countdown_alarm
  import ca_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              week_hit,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int SYNC_N = 2;

  logic [SYNC_N-1:0]  rst_sync;
  logic               rst_n_i;
  logic [CNT_W-1:0]   remain, load_val;
  logic               load_stb, run_en, wake_en, week_en, cnt_hit;
  logic [NUM_EVT-1:0] irq_en, clr, set, pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_N-2:0], 1'b1};
  end
  assign rst_n_i = rst_sync[SYNC_N-1];

  ca_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .remain(remain), .pend(pend), .rdata(bus_rdata), .load_stb(load_stb),
    .load_val(load_val), .run_en(run_en), .irq_en(irq_en), .wake_en(wake_en),
    .week_en(week_en), .clr(clr)
  );

  ca_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .run_en(run_en), .tick(sec_tick),
    .load_stb(load_stb), .load_val(load_val), .remain(remain), .hit(cnt_hit)
  );

  assign set[EVT_CNT]  = cnt_hit;
  assign set[EVT_WEEK] = week_hit && week_en;

  for (genvar e = 0; e < NUM_EVT; e++) begin : g_pend
    ca_pend u_pend (
      .clk(clk), .rst_n(rst_n_i), .set(set[e]), .clr(clr[e]), .q(pend[e])
    );
  end

  assign irq_o  = |(pend & irq_en);
  assign wake_o = pend[EVT_CNT] & wake_en;

  assert_fire_at_one_R4: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(pend[EVT_CNT]) |-> $past(remain) == CNT_W'(1));
  assert_week_gated_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(pend[EVT_WEEK]) |-> $past(week_en));
  assert_irq_path_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    (pend[EVT_CNT] && irq_en[EVT_CNT]) |-> irq_o);
  assert_wake_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
    !pend[EVT_CNT] |-> !wake_o);
endmodule

// File: tb/sec_countdown_alarm_test.sv
`timescale 1ns/1ps
module sec_countdown_alarm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sec_tick = 1'b0, week_hit = 1'b0, bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, wake_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sec_countdown_alarm uut (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .week_hit(week_hit),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .wake_o(wake_o)
  );

  localparam logic [3:0] OP_WR = 0, OP_RD = 1, OP_TK = 2, OP_OUT = 3, OP_WK = 4;
  localparam int NV = 41;
  // {op, index, data, expected, requirement}
  localparam logic [79:0] VEC [NV] = '{
    {OP_RD, 4'd1, 32'd0, 32'd0, 8'd1},          // R1 remaining is zero
    {OP_OUT,4'd0, 32'd0, 32'd0, 8'd1},          // R1 outputs low
    {OP_WR, 4'd0, 32'd5, 32'd0, 8'd2},
    {OP_RD, 4'd1, 32'd0, 32'd5, 8'd2},          // R2 load to remaining
    {OP_RD, 4'd0, 32'd0, 32'd5, 8'd2},          // R2 load readback
    {OP_TK, 4'd0, 32'd3, 32'd0, 8'd3},
    {OP_RD, 4'd1, 32'd0, 32'd5, 8'd3},          // R3 stopped: no change
    {OP_WR, 4'd2, 32'd1, 32'd0, 8'd3},
    {OP_TK, 4'd0, 32'd3, 32'd0, 8'd3},
    {OP_RD, 4'd1, 32'd0, 32'd2, 8'd3},          // R3 three ticks
    {OP_OUT,4'd0, 32'd0, 32'd0, 8'd8},
    {OP_WR, 4'd3, 32'd1, 32'd0, 8'd8},
    {OP_TK, 4'd0, 32'd1, 32'd0, 8'd4},
    {OP_RD, 4'd4, 32'd0, 32'd0, 8'd4},          // R4 not yet at one
    {OP_TK, 4'd0, 32'd1, 32'd0, 8'd4},
    {OP_RD, 4'd1, 32'd0, 32'd0, 8'd4},
    {OP_RD, 4'd4, 32'd0, 32'd1, 8'd4},          // R4 pending set
    {OP_OUT,4'd0, 32'd0, 32'd1, 8'd8},          // R8 irq only
    {OP_WR, 4'd5, 32'd1, 32'd0, 8'd8},
    {OP_OUT,4'd0, 32'd0, 32'd3, 8'd8},          // R8 irq and wake
    {OP_TK, 4'd0, 32'd2, 32'd0, 8'd4},
    {OP_RD, 4'd1, 32'd0, 32'd0, 8'd4},          // R4 parks at zero
    {OP_WR, 4'd4, 32'd0, 32'd0, 8'd6},
    {OP_RD, 4'd4, 32'd0, 32'd1, 8'd6},          // R6 write 0 keeps
    {OP_WR, 4'd4, 32'd1, 32'd0, 8'd6},
    {OP_RD, 4'd4, 32'd0, 32'd0, 8'd6},          // R6 write 1 clears
    {OP_OUT,4'd0, 32'd0, 32'd0, 8'd8},
    {OP_WR, 4'd0, 32'd0, 32'd0, 8'd5},
    {OP_TK, 4'd0, 32'd2, 32'd0, 8'd5},
    {OP_RD, 4'd4, 32'd0, 32'd0, 8'd5},          // R5 zero load silent
    {OP_WR, 4'd0, 32'hFFFFFFFF, 32'd0, 8'd11},
    {OP_TK, 4'd0, 32'd1, 32'd0, 8'd11},
    {OP_RD, 4'd1, 32'd0, 32'hFFFFFFFE, 8'd11},  // R11 full width
    {OP_WR, 4'd6, 32'd1, 32'd0, 8'd10},
    {OP_WR, 4'd7, 32'd1, 32'd0, 8'd10},
    {OP_WK, 4'd0, 32'd0, 32'd0, 8'd10},
    {OP_RD, 4'd8, 32'd0, 32'd1, 8'd10},         // R10 weekly pending
    {OP_OUT,4'd0, 32'd0, 32'd1, 8'd10},         // R10 irq, no wake
    {OP_WR, 4'd9, 32'd5, 32'd0, 8'd12},
    {OP_RD, 4'd9, 32'd0, 32'd0, 8'd12},         // R12 unmapped reads 0
    {OP_RD, 4'd2, 32'd0, 32'd1, 8'd12}          // R12 run bit unchanged
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int rq);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input int rq);
    @(negedge clk); bus_addr = a; #1;
    check(bus_rdata, exp, rq);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sec_tick = 1'b1;
      @(negedge clk); sec_tick = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      logic [3:0] op, a;
      logic [31:0] d, e;
      int rq;
      op = VEC[i][79:76]; a = VEC[i][75:72]; d = VEC[i][71:40];
      e = VEC[i][39:8]; rq = int'(VEC[i][7:0]);
      case (op)
        OP_WR: wr(a, d);
        OP_RD: rd(a, e, rq);
        OP_TK: ticks(int'(d));
        OP_OUT: begin @(negedge clk); #1; check({30'd0, wake_o, irq_o}, e, rq); end
        OP_WK: begin @(negedge clk); week_hit = 1'b1; @(negedge clk); week_hit = 1'b0; end
        default: ;
      endcase
    end
    // R10: weekly clear, then a hit with weekly enable off is ignored
    wr(4'd8, 32'd1);
    rd(4'd8, 32'd0, 10);
    wr(4'd6, 32'd0);
    @(negedge clk); week_hit = 1'b1; @(negedge clk); week_hit = 1'b0;
    rd(4'd8, 32'd0, 10);
    // R9: load collides with a running tick
    wr(4'd0, 32'd10);
    @(negedge clk); sec_tick = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'd7;
    @(negedge clk); sec_tick = 1'b0; bus_we = 1'b0;
    rd(4'd1, 32'd7, 9);
    // R7: expiry collides with a status clear
    wr(4'd0, 32'd1);
    @(negedge clk); sec_tick = 1'b1; bus_we = 1'b1; bus_addr = 4'd4; bus_wdata = 32'd1;
    @(negedge clk); sec_tick = 1'b0; bus_we = 1'b0;
    rd(4'd4, 32'd1, 7);
    rd(4'd1, 32'd0, 7);
    // R1: reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    check({30'd0, wake_o, irq_o}, 32'd0, 1);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    rd(4'd2, 32'd0, 1);
    rd(4'd4, 32'd0, 1);
    rd(4'd0, 32'd0, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule